// File: doc/BRIEF.md
# Boundary-scan test program sequencer

This block runs a short test program stored in its own instruction memory and drives a serial test port (TCK and TMS) on behalf of a board-level boundary-scan test. Each 16-bit instruction carries a 4-bit opcode in bits 15:12 and a 12-bit operand in bits 11:0. The instruction set covers single TCK cycles with a chosen TMS level, counted runs of TCK cycles with TMS low, a loadable cycle counter, scan-chain selection, a synchronisation pin pair for handshakes with outside equipment, error-flag selection, conditional jumps on an error flag, and program termination.

Scan shifts are not done here. A shift instruction pulses `shift_start` and waits for a separate shift-and-compare engine to answer with `shift_done`. The engine reports a mismatch on `shift_fail`, and that sets the error flag currently selected. The testbench writes the program through a simple write port while the sequencer is not running, then pulses `start`. Execution begins at address 0.

Top module: `bscan_seq_top`

## Requirements
- R1: Opcode 1 gives exactly one TCK pulse, with TMS equal to operand bit 0 during that pulse, and then goes on to the next address.
- R2: Opcode 2 gives N TCK pulses with TMS at 0, where N is the value held in the cycle counter.
- R3: Opcode 3 writes operand bits 11:0 into the cycle counter. The counter keeps its value across later idle runs.
- R4: Opcode 4 sets `chain_sel` to the low operand bits, and it holds until the next opcode 4 or the next start.
- R5: Opcode 5 sets `sync_out` to operand bit 0.
- R6: Opcode 6 stalls, with no TCK activity, until `sync_in` equals operand bit 0, and then goes on.
- R7: Opcode 7 selects error flag number operand[FLAG_W-1:0]. Opcode 9 pulses `shift_start` for exactly one clock and waits for `shift_done`. If `shift_fail` is high with `shift_done`, the selected bit of `err_flags` is set. Otherwise the flags are unchanged.
- R8: Opcode 8 jumps to address operand[ADDR_W-1:0] when the selected error flag equals operand bit 11. Otherwise it goes on to the next address.
- R9: Opcode 0 stops execution, raises `done` and drops `busy`. Both hold until the next start.
- R10: Opcodes 10 to 15 stop execution with `illegal` high and `done` low.
- R11: TCK runs at half the system clock: each high phase lasts exactly one clock. TMS changes only while TCK is low.
- R12: An opcode 2 with the counter at zero finishes with no TCK pulse.
- R13: After reset all outputs are 0. A start pulse clears the counter, chain, `sync_out`, flag selection, flags, `done` and `illegal`, and begins execution at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we | input | 1 | Program memory write enable |
| prog_addr | input | ADDR_W | Program memory write address |
| prog_wdata | input | 16 | Instruction word to write |
| start | input | 1 | Begin execution at address 0 (ignored while busy) |
| sync_in | input | 1 | Synchronisation input tested by opcode 6 |
| shift_done | input | 1 | Shift engine finished |
| shift_fail | input | 1 | Shift engine found a mismatch (valid with shift_done) |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| sync_out | output | 1 | Synchronisation output set by opcode 5 |
| chain_sel | output | CHAIN_W | Scan chain selected for shifts |
| shift_start | output | 1 | One-clock request to the shift engine |
| err_flags | output | 2**FLAG_W | Error flags |
| busy | output | 1 | Program running |
| done | output | 1 | Program ended on opcode 0 |
| illegal | output | 1 | Program stopped on an unknown opcode |

## Verification
The assertions take several things as given about the inputs. `sync_in` is already synchronous to `clk`. `shift_done` arrives only after `shift_start`, as a single-clock pulse. The program memory is not written while the sequencer runs. The bench keeps to these assumptions in three ways. Program words are written only between runs. Its shift engine model answers three clocks after each start pulse, with a one-clock done. `sync_in` changes only away from the active clock edge, long after the stalling instruction has been reached.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    localparam int OPC_W   = 4;
    localparam int ARG_W   = 12;
    localparam int INSTR_W = OPC_W + ARG_W;

    typedef enum logic [OPC_W-1:0] {
        OP_END   = 4'd0,
        OP_TMS   = 4'd1,
        OP_IDLE  = 4'd2,
        OP_LOAD  = 4'd3,
        OP_CHAIN = 4'd4,
        OP_SSET  = 4'd5,
        OP_SWAIT = 4'd6,
        OP_FLAG  = 4'd7,
        OP_JUMP  = 4'd8,
        OP_SHIFT = 4'd9
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_CLK   = 3'd2,
        ST_SHIFT = 3'd3,
        ST_HALT  = 3'd4
    } st_e;

endpackage

// File: rtl/bsq_progmem.sv
module bsq_progmem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Combinational read: one instruction is decoded per clock.
    assign rdata = mem_q[raddr];

endmodule

// File: rtl/bsq_clkgen.sv
module bsq_clkgen #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [CNT_W-1:0] go_cnt,
    input  logic             go_tms,
    output logic             tck,
    output logic             tms,
    output logic             fin
);
    typedef struct packed {
        logic             active;
        logic             tck;
        logic             tms;
        logic [CNT_W-1:0] rem;
    } cg_t;

    cg_t q, n;

    always_comb begin
        n   = q;
        fin = q.active && q.tck && (q.rem == CNT_W'(1));
        if (go) begin
            n.active = 1'b1;
            n.rem    = go_cnt;
            n.tms    = go_tms;
        end else if (q.active) begin
            if (!q.tck) begin
                n.tck = 1'b1;
            end else begin
                n.tck = 1'b0;
                n.rem = q.rem - CNT_W'(1);
                if (q.rem == CNT_W'(1)) begin
                    n.active = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign tck = q.tck;
    assign tms = q.tms;

    // R11: the high phase of TCK lasts exactly one system clock.
    a_r11_tck_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
        q.tck |=> !q.tck);

    // R11: TMS may only move while TCK is low.
    a_r11_tms_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.tms) |-> !$past(q.tck));

    // R2: a new burst is never requested while one is running, and never with zero length.
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (!q.active && go_cnt != '0));

endmodule

// File: rtl/bsq_core.sv
module bsq_core
    import bsq_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int CNT_W   = 12,
    parameter int CHAIN_W = 3,
    parameter int FLAG_W  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [INSTR_W-1:0]    instr,
    output logic [ADDR_W-1:0]     pc,
    input  logic                  sync_in,
    input  logic                  shift_done,
    input  logic                  shift_fail,
    input  logic                  clk_fin,
    output logic                  go,
    output logic [CNT_W-1:0]      go_cnt,
    output logic                  go_tms,
    output logic [CHAIN_W-1:0]    chain_sel,
    output logic                  sync_out,
    output logic                  shift_start,
    output logic [(1<<FLAG_W)-1:0] err_flags,
    output logic                  busy,
    output logic                  done,
    output logic                  illegal
);
    localparam int NFLAG = 1 << FLAG_W;

    typedef struct packed {
        st_e                state;
        logic [ADDR_W-1:0]  pc;
        logic [CNT_W-1:0]   cnt;
        logic [CHAIN_W-1:0] chain;
        logic [FLAG_W-1:0]  fsel;
        logic [NFLAG-1:0]   flags;
        logic               sync;
        logic               sstart;
        logic               done;
        logic               ill;
    } core_t;

    core_t q, n;

    op_e               opc;
    logic [ARG_W-1:0]  arg;
    logic [ADDR_W-1:0] pc_inc;

    assign opc    = op_e'(instr[INSTR_W-1:ARG_W]);
    assign arg    = instr[ARG_W-1:0];
    assign pc_inc = q.pc + ADDR_W'(1);

    always_comb begin
        n        = q;
        n.sstart = 1'b0;
        go       = 1'b0;
        go_cnt   = q.cnt;
        go_tms   = 1'b0;
        unique case (q.state)
            ST_IDLE, ST_HALT: begin
                if (start) begin
                    n       = core_t'('0);
                    n.state = ST_RUN;
                end
            end
            ST_RUN: begin
                case (opc)
                    OP_END: begin
                        n.done  = 1'b1;
                        n.state = ST_HALT;
                    end
                    OP_TMS: begin
                        go      = 1'b1;
                        go_cnt  = CNT_W'(1);
                        go_tms  = arg[0];
                        n.state = ST_CLK;
                    end
                    OP_IDLE: begin
                        if (q.cnt == '0) begin
                            n.pc = pc_inc;
                        end else begin
                            go      = 1'b1;
                            n.state = ST_CLK;
                        end
                    end
                    OP_LOAD: begin
                        n.cnt = arg[CNT_W-1:0];
                        n.pc  = pc_inc;
                    end
                    OP_CHAIN: begin
                        n.chain = arg[CHAIN_W-1:0];
                        n.pc    = pc_inc;
                    end
                    OP_SSET: begin
                        n.sync = arg[0];
                        n.pc   = pc_inc;
                    end
                    OP_SWAIT: begin
                        if (sync_in == arg[0]) begin
                            n.pc = pc_inc;
                        end
                    end
                    OP_FLAG: begin
                        n.fsel = arg[FLAG_W-1:0];
                        n.pc   = pc_inc;
                    end
                    OP_JUMP: begin
                        if (q.flags[q.fsel] == arg[ARG_W-1]) begin
                            n.pc = arg[ADDR_W-1:0];
                        end else begin
                            n.pc = pc_inc;
                        end
                    end
                    OP_SHIFT: begin
                        n.sstart = 1'b1;
                        n.state  = ST_SHIFT;
                    end
                    default: begin
                        n.ill   = 1'b1;
                        n.state = ST_HALT;
                    end
                endcase
            end
            ST_CLK: begin
                if (clk_fin) begin
                    n.pc    = pc_inc;
                    n.state = ST_RUN;
                end
            end
            ST_SHIFT: begin
                if (shift_done) begin
                    if (shift_fail) begin
                        n.flags[q.fsel] = 1'b1;
                    end
                    n.pc    = pc_inc;
                    n.state = ST_RUN;
                end
            end
            default: n.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= core_t'('0);
        end else begin
            q <= n;
        end
    end

    assign pc          = q.pc;
    assign chain_sel   = q.chain;
    assign sync_out    = q.sync;
    assign shift_start = q.sstart;
    assign err_flags   = q.flags;
    assign busy        = (q.state == ST_RUN) || (q.state == ST_CLK) || (q.state == ST_SHIFT);
    assign done        = q.done;
    assign illegal     = q.ill;

    // R6: an unmet wait keeps the program counter and state unchanged.
    a_r6_wait_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RUN && opc == OP_SWAIT && sync_in != arg[0])
        |=> ($stable(q.pc) && q.state == ST_RUN));

    // R7: the shift request is a single-clock pulse followed by waiting.
    a_r7_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.sstart |=> (!q.sstart && (q.state == ST_SHIFT || q.state == ST_RUN)));

    // R7: flags only rise on a failing shift completion.
    a_r7_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_IDLE && q.state != ST_HALT && !(shift_done && shift_fail))
        |=> $stable(q.flags));

    // R9: end status holds until a new start.
    a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && !start) |=> (q.done && !busy));

    // R10: an illegal stop never reports normal completion.
    a_r10_ill_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.ill && q.done));

    // R12: a zero-count idle run advances on the next clock.
    a_r12_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RUN && opc == OP_IDLE && q.cnt == '0)
        |=> (q.state == ST_RUN && q.pc == $past(pc_inc)));

endmodule

// File: rtl/bscan_seq_top.sv
module bscan_seq_top
    import bsq_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int CNT_W   = 12,
    parameter int CHAIN_W = 3,
    parameter int FLAG_W  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   prog_we,
    input  logic [ADDR_W-1:0]      prog_addr,
    input  logic [15:0]            prog_wdata,
    input  logic                   start,
    input  logic                   sync_in,
    input  logic                   shift_done,
    input  logic                   shift_fail,
    output logic                   tck,
    output logic                   tms,
    output logic                   sync_out,
    output logic [CHAIN_W-1:0]     chain_sel,
    output logic                   shift_start,
    output logic [(1<<FLAG_W)-1:0] err_flags,
    output logic                   busy,
    output logic                   done,
    output logic                   illegal
);
    logic [INSTR_W-1:0] instr;
    logic [ADDR_W-1:0]  pc;
    logic               go;
    logic [CNT_W-1:0]   go_cnt;
    logic               go_tms;
    logic               clk_fin;

    bsq_progmem #(.ADDR_W(ADDR_W), .DATA_W(INSTR_W)) i_mem (
        .clk   (clk),
        .we    (prog_we),
        .waddr (prog_addr),
        .wdata (prog_wdata),
        .raddr (pc),
        .rdata (instr)
    );

    bsq_core #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .CHAIN_W(CHAIN_W),
        .FLAG_W (FLAG_W)
    ) i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .instr      (instr),
        .pc         (pc),
        .sync_in    (sync_in),
        .shift_done (shift_done),
        .shift_fail (shift_fail),
        .clk_fin    (clk_fin),
        .go         (go),
        .go_cnt     (go_cnt),
        .go_tms     (go_tms),
        .chain_sel  (chain_sel),
        .sync_out   (sync_out),
        .shift_start(shift_start),
        .err_flags  (err_flags),
        .busy       (busy),
        .done       (done),
        .illegal    (illegal)
    );

    bsq_clkgen #(.CNT_W(CNT_W)) i_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .go_cnt(go_cnt),
        .go_tms(go_tms),
        .tck   (tck),
        .tms   (tms),
        .fin   (clk_fin)
    );

endmodule

// File: tb/test_bscan_seq_top.sv
module test_bscan_seq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [15:0] prog_wdata = '0;
    logic        start = 1'b0;
    logic        sync_in = 1'b0;
    logic        shift_done = 1'b0;
    logic        shift_fail = 1'b0;
    logic        tck, tms, sync_out, shift_start, busy, done, illegal;
    logic [2:0]  chain_sel;
    logic [3:0]  err_flags;

    always #2 clk = ~clk;   // 250 MHz

    bscan_seq_top i_bscan_seq_top (
        .clk, .rst_n, .prog_we, .prog_addr, .prog_wdata, .start, .sync_in,
        .shift_done, .shift_fail, .tck, .tms, .sync_out, .chain_sel,
        .shift_start, .err_flags, .busy, .done, .illegal
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input int req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---- TCK observer and shift engine model (act 1 ns after each edge)
    int   pulses = 0;
    int   ones = 0;
    int   tim_err = 0;
    logic tck_p = 1'b0, tms_p = 1'b0, ss_p = 1'b0;
    logic fail_cfg = 1'b0;
    int   sh_cnt = 0;

    always @(posedge clk) begin
        #1;
        if (tck && !tck_p) begin
            pulses++;
            if (tms) ones++;
        end
        if (tck && tck_p) tim_err++;              // high longer than one clock
        if (tms != tms_p && tck_p) tim_err++;     // TMS moved while TCK high
        if (shift_start && ss_p) tim_err++;       // request wider than one clock
        tck_p = tck;
        tms_p = tms;
        ss_p  = shift_start;
        shift_done = 1'b0;
        if (sh_cnt != 0) begin
            sh_cnt--;
            if (sh_cnt == 0) begin
                shift_done = 1'b1;
                shift_fail = fail_cfg;
            end
        end
        if (shift_start) sh_cnt = 3;
    end

    // ---- vector table
    typedef struct packed {
        logic [4:0]   req;
        logic         fail;
        logic [127:0] prog;     // word 0 in the top 16 bits
        logic [7:0]   pulses;
        logic [7:0]   ones;
        logic         done;
        logic         ill;
        logic [2:0]   chain;
        logic         sync;
        logic [3:0]   flags;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        // R1: two single cycles, TMS 1 then 0
        '{5'd1,  1'b0, 128'h1001_1000_0000_0000_0000_0000_0000_0000, 8'd2, 8'd1, 1'b1, 1'b0, 3'd0, 1'b0, 4'h0},
        // R2: load 5 then idle run
        '{5'd2,  1'b0, 128'h3005_2000_0000_0000_0000_0000_0000_0000, 8'd5, 8'd0, 1'b1, 1'b0, 3'd0, 1'b0, 4'h0},
        // R13: counter cleared by start, idle gives nothing
        '{5'd13, 1'b0, 128'h2000_0000_0000_0000_0000_0000_0000_0000, 8'd0, 8'd0, 1'b1, 1'b0, 3'd0, 1'b0, 4'h0},
        // R12: zero count, then one TMS=1 cycle
        '{5'd12, 1'b0, 128'h3000_2000_1001_0000_0000_0000_0000_0000, 8'd1, 8'd1, 1'b1, 1'b0, 3'd0, 1'b0, 4'h0},
        // R3: counter kept across two idle runs
        '{5'd3,  1'b0, 128'h3003_2000_2000_0000_0000_0000_0000_0000, 8'd6, 8'd0, 1'b1, 1'b0, 3'd0, 1'b0, 4'h0},
        // R4 / R5: chain 5, sync output 1
        '{5'd4,  1'b0, 128'h4005_5001_0000_0000_0000_0000_0000_0000, 8'd0, 8'd0, 1'b1, 1'b0, 3'd5, 1'b1, 4'h0},
        // R13: start clears chain and sync output
        '{5'd13, 1'b0, 128'h0000_0000_0000_0000_0000_0000_0000_0000, 8'd0, 8'd0, 1'b1, 1'b0, 3'd0, 1'b0, 4'h0},
        // R7: flag 2 selected, failing shift
        '{5'd7,  1'b1, 128'h7002_9000_0000_0000_0000_0000_0000_0000, 8'd0, 8'd0, 1'b1, 1'b0, 3'd0, 1'b0, 4'h4},
        // R7: passing shift leaves flags clear
        '{5'd7,  1'b0, 128'h7001_9000_0000_0000_0000_0000_0000_0000, 8'd0, 8'd0, 1'b1, 1'b0, 3'd0, 1'b0, 4'h0},
        // R8: flag 3 set, jump-if-1 taken over the TMS cycle
        '{5'd8,  1'b1, 128'h7003_9000_8804_1001_0000_0000_0000_0000, 8'd0, 8'd0, 1'b1, 1'b0, 3'd0, 1'b0, 4'h8},
        // R8: flag 3 clear, jump not taken
        '{5'd8,  1'b0, 128'h7003_9000_8804_1001_0000_0000_0000_0000, 8'd1, 8'd1, 1'b1, 1'b0, 3'd0, 1'b0, 4'h0},
        // R8: jump-if-0 on clear flag 0 taken
        '{5'd8,  1'b0, 128'h8003_1001_1001_0000_0000_0000_0000_0000, 8'd0, 8'd0, 1'b1, 1'b0, 3'd0, 1'b0, 4'h0},
        // R10: opcode 10 halts before the last TMS cycle
        '{5'd10, 1'b0, 128'h1001_A000_1001_0000_0000_0000_0000_0000, 8'd1, 8'd1, 1'b0, 1'b1, 3'd0, 1'b0, 4'h0},
        // R9: end at address 0 stops everything after it
        '{5'd9,  1'b0, 128'h0000_1001_1001_0000_0000_0000_0000_0000, 8'd0, 8'd0, 1'b1, 1'b0, 3'd0, 1'b0, 4'h0}
    };

    task automatic load_prog(input logic [127:0] p);
        for (int w = 0; w < 8; w++) begin
            @(negedge clk);
            prog_we    = 1'b1;
            prog_addr  = 6'(w);
            prog_wdata = p[127-16*w -: 16];
        end
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic run_prog(input int req);
        int waited;
        @(negedge clk);
        pulses = 0;
        ones   = 0;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        waited = 0;
        while (busy && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        chk(req, "run finished", int'(waited < 2000), 1);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state
        chk(13, "reset tck", int'(tck), 0);
        chk(13, "reset tms", int'(tms), 0);
        chk(13, "reset busy", int'(busy), 0);
        chk(13, "reset done", int'(done), 0);
        chk(13, "reset illegal", int'(illegal), 0);
        chk(13, "reset flags", int'(err_flags), 0);
        chk(13, "reset shift_start", int'(shift_start), 0);

        for (int v = 0; v < NV; v++) begin
            fail_cfg = VECS[v].fail;
            load_prog(VECS[v].prog);
            run_prog(int'(VECS[v].req));
            chk(int'(VECS[v].req), "tck pulses", pulses, int'(VECS[v].pulses));
            chk(int'(VECS[v].req), "pulses with tms=1", ones, int'(VECS[v].ones));
            chk(int'(VECS[v].req), "done", int'(done), int'(VECS[v].done));
            chk(int'(VECS[v].req), "illegal", int'(illegal), int'(VECS[v].ill));
            chk(int'(VECS[v].req), "chain_sel", int'(chain_sel), int'(VECS[v].chain));
            chk(int'(VECS[v].req), "sync_out", int'(sync_out), int'(VECS[v].sync));
            chk(int'(VECS[v].req), "err_flags", int'(err_flags), int'(VECS[v].flags));
        end

        // R6: wait for sync_in high, then one TMS=1 cycle
        sync_in = 1'b0;
        load_prog(128'h6001_1001_0000_0000_0000_0000_0000_0000);
        @(negedge clk);
        pulses = 0;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        repeat (20) @(negedge clk);
        chk(6, "stalled busy", int'(busy), 1);
        chk(6, "stalled pulses", pulses, 0);
        sync_in = 1'b1;
        repeat (20) @(negedge clk);
        chk(6, "released busy", int'(busy), 0);
        chk(6, "released pulses", pulses, 1);

        // R9: done holds with no new start
        repeat (10) @(negedge clk);
        chk(9, "done held", int'(done), 1);

        // R11: timing of TCK and TMS over the whole run
        chk(11, "tck/tms timing violations", tim_err, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule